// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block is the shift stage of an ALU operand path for shifts whose distance is held in a register. It takes a 32-bit data word, a 32-bit distance operand, a 2-bit operation code and the incoming carry flag. It returns the shifted word and the new carry flag. The supported operations are logical left, logical right, arithmetic right and rotate right.

Only the bottom byte of the distance operand counts. A distance of zero, a distance of exactly the word width, and distances beyond the word width each follow their own rules for both the result and the carry. The rotate operation also has a special case for a nonzero byte whose low five bits are all clear.

The result and carry are registered once, so they appear one clock after the inputs. An active-low asynchronous reset clears both outputs.

Top module: `regshift_unit`

## Requirements
- R1: Only bits [7:0] of `amt_i` set the distance. Bits [31:8] have no effect on either output.
- R2: `op_i` selects the operation: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R3: When the distance byte is zero, the result equals `val_i` and the carry equals `cin_i`, for every operation.
- R4: Logical left by 1..31 shifts zeros in at the bottom. The carry is `val_i[32-n]`.
- R5: Logical left by exactly 32 gives result 0 and carry `val_i[0]`. Logical left by 33..255 gives result 0 and carry 0.
- R6: Logical right by 1..31 shifts zeros in at the top with carry `val_i[n-1]`. By exactly 32 it gives result 0 and carry `val_i[31]`. By 33..255 it gives result 0 and carry 0.
- R7: Arithmetic right by 1..31 fills the top with copies of `val_i[31]`, with carry `val_i[n-1]`. By 32..255 every result bit and the carry equal `val_i[31]`.
- R8: Rotate right uses the rotation r = n mod 32. When r is nonzero, the result is `val_i` rotated right by r and the carry is `val_i[r-1]`.
- R9: Rotate right with a nonzero distance byte that is a multiple of 32 (32, 64, ..., 224) returns `val_i` unchanged, with carry `val_i[31]`.
- R10: The result and carry register one clock after their inputs are applied. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code (see R2) |
| val_i | input | 32 | Data word to shift |
| amt_i | input | 32 | Distance operand; only bits [7:0] are used |
| cin_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Registered shifted word |
| cout_o | output | 1 | Registered new carry flag |

## Verification
The bench sweeps every distance byte from 0 to 255 for all four operations. It uses random data words and random upper operand bits, so it covers the points where the rules change: 0, 31, 32, 33, and the multiples of 32 for rotate.

Each wrong design shows up differently:
- A design that decodes more than the low byte gives wrong results on distances such as 0x100.
- A design that clamps at 32 without separating "exactly 32" from "beyond" returns the wrong carry at one of those two points.
- A design that treats a rotate by 64 as a rotate by zero keeps the old carry instead of taking bit 31.
- A design with an off-by-one carry index shows it on every nonzero distance below 32.

// File: rtl/shf_pkg.sv
package shf_pkg;

    parameter int SHF_DW = 32;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shf_op_e;

endpackage

// File: rtl/shf_amt_decode.sv
// Classifies the distance byte into the ranges that select different rules.
module shf_amt_decode #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SW    = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] cnt_i,
    output logic             is_zero_o,
    output logic             is_small_o,
    output logic             is_exact_o,
    output logic [SW-1:0]    low_o
);

    localparam logic [AMT_W-1:0] WIDTH_CNT = AMT_W'(DATA_W);

    always_comb begin
        is_zero_o  = (cnt_i == '0);
        is_exact_o = (cnt_i == WIDTH_CNT);
        is_small_o = !is_zero_o && (cnt_i < WIDTH_CNT);
        low_o      = cnt_i[SW-1:0];
    end

endmodule

// File: rtl/shf_rotr.sv
// Logarithmic right rotator: one stage per bit of the rotation amount.
module shf_rotr #(
    parameter int DATA_W = 32,
    localparam int SW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [SW-1:0]     rot_i,
    output logic [DATA_W-1:0] rot_o
);

    logic [DATA_W-1:0] stg [SW+1];

    assign stg[0] = val_i;

    for (genvar g = 0; g < SW; g++) begin : g_stage
        localparam int STEP = 1 << g;
        assign stg[g+1] = rot_i[g] ? {stg[g][STEP-1:0], stg[g][DATA_W-1:STEP]}
                                   : stg[g];
    end

    assign rot_o = stg[SW];

endmodule

// File: rtl/shf_result_sel.sv
// Picks result and carry per operation and distance range.
module shf_result_sel
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SW    = $clog2(DATA_W)
) (
    input  shf_op_e           op_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic              cin_i,
    input  logic              is_zero_i,
    input  logic              is_small_i,
    input  logic              is_exact_i,
    input  logic [SW-1:0]     low_i,
    input  logic [DATA_W-1:0] rot_r_i,
    input  logic [DATA_W-1:0] rot_l_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    logic [DATA_W-1:0] mask_r;
    logic [DATA_W-1:0] mask_l;
    logic [SW-1:0]     idx_dn;
    logic [SW-1:0]     idx_up;
    logic              sign;

    always_comb begin
        mask_r = {DATA_W{1'b1}} >> low_i;
        mask_l = {DATA_W{1'b1}} << low_i;
        idx_dn = low_i - SW'(1);
        idx_up = SW'(0) - low_i;
        sign   = val_i[DATA_W-1];

        res_o  = val_i;
        cout_o = cin_i;

        if (!is_zero_i) begin
            unique case (op_i)
                SH_LSL: begin
                    if (is_small_i) begin
                        res_o  = rot_l_i & mask_l;
                        cout_o = val_i[idx_up];
                    end else begin
                        res_o  = '0;
                        cout_o = is_exact_i ? val_i[0] : 1'b0;
                    end
                end
                SH_LSR: begin
                    if (is_small_i) begin
                        res_o  = rot_r_i & mask_r;
                        cout_o = val_i[idx_dn];
                    end else begin
                        res_o  = '0;
                        cout_o = is_exact_i ? sign : 1'b0;
                    end
                end
                SH_ASR: begin
                    if (is_small_i) begin
                        res_o  = (rot_r_i & mask_r) | (sign ? ~mask_r : '0);
                        cout_o = val_i[idx_dn];
                    end else begin
                        res_o  = {DATA_W{sign}};
                        cout_o = sign;
                    end
                end
                default: begin
                    if (low_i != '0) begin
                        res_o  = rot_r_i;
                        cout_o = val_i[idx_dn];
                    end else begin
                        res_o  = val_i;
                        cout_o = sign;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/regshift_unit.sv
module regshift_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = SHF_DW,
    parameter int AMT_W  = 8,
    localparam int SW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic [DATA_W-1:0] amt_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cout;
    } out_t;

    out_t nxt_d;
    out_t out_q;

    logic              is_zero;
    logic              is_small;
    logic              is_exact;
    logic [SW-1:0]     low;
    logic [SW-1:0]     left_rot;
    logic [DATA_W-1:0] rot_r;
    logic [DATA_W-1:0] rot_l;
    logic [DATA_W-1:0] sel_res;
    logic              sel_cout;
    logic              unused_amt_hi;

    assign unused_amt_hi = ^amt_i[DATA_W-1:AMT_W];
    assign left_rot      = SW'(0) - low;

    shf_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
        .cnt_i      (amt_i[AMT_W-1:0]),
        .is_zero_o  (is_zero),
        .is_small_o (is_small),
        .is_exact_o (is_exact),
        .low_o      (low)
    );

    shf_rotr #(.DATA_W(DATA_W)) u_rot_r (
        .val_i (val_i),
        .rot_i (low),
        .rot_o (rot_r)
    );

    shf_rotr #(.DATA_W(DATA_W)) u_rot_l (
        .val_i (val_i),
        .rot_i (left_rot),
        .rot_o (rot_l)
    );

    shf_result_sel #(.DATA_W(DATA_W)) u_sel (
        .op_i       (shf_op_e'(op_i)),
        .val_i      (val_i),
        .cin_i      (cin_i),
        .is_zero_i  (is_zero),
        .is_small_i (is_small),
        .is_exact_i (is_exact),
        .low_i      (low),
        .rot_r_i    (rot_r),
        .rot_l_i    (rot_l),
        .res_o      (sel_res),
        .cout_o     (sel_cout)
    );

    always_comb begin
        nxt_d.res  = sel_res;
        nxt_d.cout = sel_cout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= nxt_d;
        end
    end

    assign res_o  = out_q.res;
    assign cout_o = out_q.cout;

endmodule

// File: rtl/shf_chk.sv
module shf_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] val_i,
    input logic [AMT_W-1:0]  amt_lo,
    input logic              cin_i,
    input logic [DATA_W-1:0] res_o,
    input logic              cout_o
);

    localparam logic [AMT_W-1:0] WCNT = AMT_W'(DATA_W);
    localparam int SW = $clog2(DATA_W);

    // R3
    zero_amt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_lo == '0) |=> (res_o == $past(val_i)) && (cout_o == $past(cin_i)));

    // R5
    lsl_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00 && amt_lo > WCNT) |=> (res_o == '0) && !cout_o);

    // R6
    lsr_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01 && amt_lo == WCNT) |=>
            (res_o == '0) && (cout_o == $past(val_i[DATA_W-1])));

    // R7
    asr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b10 && amt_lo >= WCNT) |=>
            (res_o == {DATA_W{$past(val_i[DATA_W-1])}}) && (cout_o == $past(val_i[DATA_W-1])));

    // R8
    ror_carry_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11 && amt_lo != '0) |=> (cout_o == res_o[DATA_W-1]));

    // R9
    ror_multiple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11 && amt_lo != '0 && amt_lo[SW-1:0] == '0) |=>
            (res_o == $past(val_i)) && (cout_o == $past(val_i[DATA_W-1])));

endmodule

bind regshift_unit shf_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .val_i  (val_i),
    .amt_lo (amt_i[AMT_W-1:0]),
    .cin_i  (cin_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/sim_regshift_unit.sv
`timescale 1ns/1ps
module sim_regshift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] val_i = '0;
    logic [31:0] amt_i = '0;
    logic        cin_i = 1'b0;
    logic [31:0] res_o;
    logic        cout_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    regshift_unit u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op_i),
        .val_i  (val_i),
        .amt_i  (amt_i),
        .cin_i  (cin_i),
        .res_o  (res_o),
        .cout_o (cout_o)
    );

    // Reference model: returns {carry, result}.
    function automatic logic [32:0] ref_shift(input logic [1:0] op, input logic [31:0] v,
                                              input logic [31:0] a, input logic c);
        int n;
        int r;
        n = int'(a[7:0]);
        if (n == 0) return {c, v};
        case (op)
            2'b00: begin
                if (n < 32) return {v[32-n], v << n};
                if (n == 32) return {v[0], 32'h0};
                return 33'h0;
            end
            2'b01: begin
                if (n < 32) return {v[n-1], v >> n};
                if (n == 32) return {v[31], 32'h0};
                return 33'h0;
            end
            2'b10: begin
                if (n < 32) return {v[n-1], 32'($signed(v) >>> n)};
                return {v[31], {32{v[31]}}};
            end
            default: begin
                r = n % 32;
                if (r == 0) return {v[31], v};
                return {v[r-1], (v >> r) | (v << (32 - r))};
            end
        endcase
    endfunction

    function automatic string op_tag(input logic [1:0] op, input logic [7:0] n);
        if (n == 8'd0) return "R3";
        case (op)
            2'b00:   return (n < 8'd32) ? "R4" : "R5";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return (n[4:0] == 5'd0) ? "R9" : "R8";
        endcase
    endfunction

    task automatic chk(input logic [1:0] op, input logic [31:0] v, input logic [31:0] a,
                       input logic c, input string tag);
        logic [32:0] exp;
        @(negedge clk);
        op_i  = op;
        val_i = v;
        amt_i = a;
        cin_i = c;
        exp   = ref_shift(op, v, a, c);
        @(negedge clk);
        n_chk++;
        if ({cout_o, res_o} !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d val=%h amt=%h cin=%0b: got res=%h c=%0b, expected res=%h c=%0b",
                     tag, op, v, a, c, res_o, cout_o, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R10: reset state
        n_chk++;
        if (res_o !== 32'h0 || cout_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: got res=%h c=%0b, expected res=0 c=0", res_o, cout_o);
        end
        rst_n = 1'b1;

        // R2: each code picks its operation
        chk(2'b00, 32'h8000_0011, 32'd4, 1'b0, "R2");
        chk(2'b01, 32'h8000_0011, 32'd4, 1'b0, "R2");
        chk(2'b10, 32'h8000_0011, 32'd4, 1'b0, "R2");
        chk(2'b11, 32'h8000_0011, 32'd4, 1'b0, "R2");
        // R1: upper bits of the distance ignored
        chk(2'b01, 32'hDEAD_BEEF, 32'hFFFF_FF00, 1'b1, "R1");
        chk(2'b00, 32'h1234_5678, 32'h1234_0104, 1'b0, "R1");
        chk(2'b11, 32'h0F0F_0001, 32'h8000_0100, 1'b0, "R1");
        // R3
        chk(2'b10, 32'h8000_0000, 32'd0, 1'b1, "R3");
        // R4
        chk(2'b00, 32'h4000_0001, 32'd1, 1'b1, "R4");
        chk(2'b00, 32'h0000_0003, 32'd31, 1'b0, "R4");
        // R5
        chk(2'b00, 32'h0000_0001, 32'd32, 1'b0, "R5");
        chk(2'b00, 32'hFFFF_FFFF, 32'd33, 1'b1, "R5");
        // R6
        chk(2'b01, 32'h8000_0000, 32'd32, 1'b0, "R6");
        chk(2'b01, 32'hFFFF_FFFF, 32'd200, 1'b1, "R6");
        chk(2'b01, 32'h8000_0000, 32'd31, 1'b0, "R6");
        // R7
        chk(2'b10, 32'h8000_0001, 32'd200, 1'b0, "R7");
        chk(2'b10, 32'h7FFF_FFFF, 32'd32, 1'b1, "R7");
        chk(2'b10, 32'h8000_0000, 32'd31, 1'b0, "R7");
        // R8
        chk(2'b11, 32'h0000_0001, 32'd1, 1'b0, "R8");
        chk(2'b11, 32'h1234_5678, 32'd255, 1'b0, "R8");
        // R9
        chk(2'b11, 32'h8765_4321, 32'd64, 1'b0, "R9");
        chk(2'b11, 32'h0765_4321, 32'd160, 1'b1, "R9");

        // Sweep every distance byte for every operation (R1 via random upper bits)
        for (int op = 0; op < 4; op++) begin
            for (int n = 0; n < 256; n++) begin
                logic [31:0] a;
                a = {$urandom() & 32'hFFFF_FF00} | 32'(n);
                chk(2'(op), $urandom(), a, 1'($urandom()), op_tag(2'(op), 8'(n)));
            end
        end

        // R10: reset clears registered outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        n_chk++;
        if (res_o !== 32'h0 || cout_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset re-entry: got res=%h c=%0b, expected res=0 c=0", res_o, cout_o);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule